// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a small status word that tells software why the system last came out of reset, and lets software ask for a new system reset. The word holds five flags in its upper bits. One flag marks a power-on reset. Two flags mark a soft power-on request and a soft externally-initiated request. Two more flags are kept for button-driven resets; in this block they can only be cleared. Every other bit reads as zero.

The power-on flags have clear-by-writing-one semantics. The soft-request flags are set by writing one. Writing one to a soft-request flag also emits a one-cycle reset request to the system sequencer, tagged with its cause. The block counts the system reset events it observes. When a reset event arrives while that count is zero, the word is loaded with the power-on flag alone. A soft power-on request returns the count to zero, so the reset it triggers is reported as a power-on.

`rst_n` clears the block at power-up: the count becomes zero and the word becomes empty. `sysrst_n` is the system reset that the block observes. Each falling edge of `sysrst_n` counts as one reset event, and bus accesses are ignored while it is low.

Top module: `rst_cause_ctrl`

## Requirements
- R1: A read with address bits 15:3 equal to 0x1E04 and address bit 2 set (offset 0xF024) returns the status word. Its flags sit at bit 31 (power-on), bit 30 (soft power-on), bit 29 (soft externally-initiated), bit 28 (button power-on) and bit 27 (button externally-initiated), and bits 26:0 read zero. The companion word at 0xF020 and every other address read zero.
- R2: After power-up clearing (`rst_n` low), the first system reset event leaves the word reading 0x80000000, and no reset request is raised.
- R3: Writing one to bit 31, 28 or 27 clears that flag. Writing zero to it leaves it unchanged, and no write can set it.
- R4: Writing one to bit 30 or 29 sets that flag. Writing zero to it never clears it; only a power-on load does.
- R5: Bits 26:0 of write data are ignored.
- R6: Writing one to bit 30 raises `rst_req` in the cycle after the write with `rst_cause` = 0 (soft power-on). `rst_req` drops in the following cycle unless another requesting write occurs.
- R7: Writing one to bit 29 while bit 30 is written as zero raises `rst_req` with `rst_cause` = 1 (externally-initiated). Writing both bits gives one request with cause 0.
- R8: A system reset event (falling edge of `sysrst_n`) while the reset count is zero loads the word with only bit 31 set. An event with a nonzero count leaves the word unchanged.
- R9: A soft power-on request (bit 30 written as one) returns the count to zero, so the next reset event loads the power-on flag.
- R10: The reset count saturates. Any number of reset events without a soft power-on request never produces a power-on load.
- R11: Writes to other addresses, and any write while `sysrst_n` is low, change nothing and raise no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-up clear; zeroes the count and the word |
| sysrst_n | input | 1 | Observed system reset, active low; each falling edge is one reset event |
| acc_en | input | 1 | Access strobe |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, combinational from address |
| rst_req | output | 1 | One-cycle system reset request |
| rst_cause | output | 1 | Cause of the request: 0 soft power-on, 1 externally-initiated |

## Verification
The assertions check the following on every cycle:
- the low 27 read bits are zero;
- soft-request flags never fall except through a power-on load, and clear-only flags never rise except through one;
- a reset event with a zero count yields exactly the power-on word, and one with a nonzero count leaves the word stable;
- the counter holds at its ceiling and drops to zero after a soft power-on request;
- every request follows a requesting write, and its cause matches the written bits;
- no request follows a cycle with `sysrst_n` low.

Only the bench scenarios can show the rest:
- that a long run of reset events never reports a false power-on;
- that the report is exact when a soft power-on request is followed by a real reset;
- that writes to the companion word or to foreign addresses leave the readable state untouched.

// File: rtl/rcc_pkg.sv
// Package: shared constants and types for the reset cause status register.
// Assumes a 32-bit data word with the five status flags in bits 31:27.
package rcc_pkg;
    localparam int RCC_DATA_W = 32;
    localparam int FLD_W      = 5;
    localparam int FLD_LSB    = RCC_DATA_W - FLD_W;

    // Field-relative flag positions (bit 31 maps to index 4).
    localparam int IDX_POR    = 4;
    localparam int IDX_SPOR   = 3;
    localparam int IDX_SXIR   = 2;
    localparam int IDX_BPOR   = 1;
    localparam int IDX_BXIR   = 0;

    localparam logic [FLD_W-1:0] W1C_MASK = 5'b10011;
    localparam logic [FLD_W-1:0] W1S_MASK = 5'b01100;
    localparam logic [FLD_W-1:0] POR_VAL  = 5'b10000;

    typedef enum logic {
        CAUSE_SOFT_POR = 1'b0,
        CAUSE_SOFT_XIR = 1'b1
    } cause_e;
endpackage

// File: rtl/rcc_decode.sv
// Module: address decode for the status word.
// Matches the 8-byte window at REG_OFF and selects the upper word (bit 2 set).
// Assumes REG_OFF is 8-byte aligned.
module rcc_decode #(
    parameter int              ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] REG_OFF = 16'hF020
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int WIN_LSB = 3;

    // Purpose: compare the window and pick the word carrying the flags.
    always_comb begin
        hit = (addr[ADDR_W-1:WIN_LSB] == REG_OFF[ADDR_W-1:WIN_LSB]) && addr[2];
    end
endmodule

// File: rtl/rcc_status.sv
// Module: the five status flags with per-bit write semantics.
// Clear-only flags use write-one-to-clear and set-only flags write-one-to-set;
// the per-bit kind is chosen from the package masks. A power-on load
// overrides any write. Assumes wr_bits is already masked to the field.
module rcc_status
    import rcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [FLD_W-1:0] wr_bits,
    input  logic             load_por,
    output logic [FLD_W-1:0] st
);
    logic [FLD_W-1:0] nxt;

    for (genvar b = 0; b < FLD_W; b++) begin : g_bit
        if (W1C_MASK[b]) begin : g_w1c
            assign nxt[b] = st[b] & ~(wr_en & wr_bits[b]);
        end else if (W1S_MASK[b]) begin : g_w1s
            assign nxt[b] = st[b] | (wr_en & wr_bits[b]);
        end else begin : g_hold
            assign nxt[b] = st[b];
        end
    end

    // Purpose: register the flags; power-on load wins over software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= '0;
        end else if (load_por) begin
            st <= POR_VAL;
        end else begin
            st <= nxt;
        end
    end

    AST_SET_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_por && st[IDX_SPOR] && st[IDX_SXIR]) |=> (st[IDX_SPOR] && st[IDX_SXIR])); // R4
    AST_CLR_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_por && !st[IDX_BPOR] && !st[IDX_BXIR]) |=> (!st[IDX_BPOR] && !st[IDX_BXIR])); // R3
endmodule

// File: rtl/rcc_event_count.sv
// Module: saturating count of observed system reset events.
// Cleared by power-up and by a soft power-on request; holds at its ceiling
// so it never wraps back to zero.
module rcc_event_count #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    output logic is_zero
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt;

    // Purpose: count events, saturate at the ceiling, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (evt && cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign is_zero = (cnt == '0);

    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !clr) |=> (cnt == CNT_MAX)); // R10
    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> is_zero); // R9
endmodule

// File: rtl/rcc_req.sv
// Module: registered reset request pulse with its cause tag.
// A soft power-on request takes priority over an externally-initiated one.
module rcc_req
    import rcc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire_por,
    input  logic fire_xir,
    output logic req,
    output logic cause
);
    // Purpose: raise the request for one cycle per firing write and tag it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req   <= 1'b0;
            cause <= CAUSE_SOFT_POR;
        end else begin
            req <= fire_por | fire_xir;
            if (fire_por) begin
                cause <= CAUSE_SOFT_POR;
            end else if (fire_xir) begin
                cause <= CAUSE_SOFT_XIR;
            end
        end
    end
endmodule

// File: rtl/rst_cause_ctrl.sv
// Module: reset cause status register, top level.
// Detects system reset events, decodes accesses to the status word, updates
// the flags, tracks power-on status through a saturating event count and
// issues soft reset requests. Assumes rst_n is a synchronous power-up clear
// and that sysrst_n is synchronous to clk.
module rst_cause_ctrl
    import rcc_pkg::*;
#(
    parameter int                ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] REG_OFF = 16'hF020,
    parameter int                CNT_W   = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sysrst_n,
    input  logic                  acc_en,
    input  logic                  acc_we,
    input  logic [ADDR_W-1:0]     acc_addr,
    input  logic [RCC_DATA_W-1:0] acc_wdata,
    output logic [RCC_DATA_W-1:0] acc_rdata,
    output logic                  rst_req,
    output logic                  rst_cause
);
    logic             sysrst_q;
    logic             evt;
    logic             hit;
    logic             wr_en;
    logic [FLD_W-1:0] wr_bits;
    logic             cnt_zero;
    logic             load_por;
    logic             fire_por;
    logic             fire_xir;
    logic [FLD_W-1:0] st;

    // Purpose: remember the previous system reset level to find its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sysrst_q <= 1'b1;
        end else begin
            sysrst_q <= sysrst_n;
        end
    end

    // Purpose: form the reset event, the write strobe and the request triggers.
    always_comb begin
        evt      = !sysrst_n && sysrst_q;
        wr_en    = acc_en && acc_we && hit && sysrst_n;
        wr_bits  = acc_wdata[RCC_DATA_W-1:FLD_LSB];
        load_por = evt && cnt_zero;
        fire_por = wr_en && wr_bits[IDX_SPOR];
        fire_xir = wr_en && wr_bits[IDX_SXIR] && !wr_bits[IDX_SPOR];
    end

    // Purpose: return the flags in the upper bits on a read hit, zero elsewhere.
    always_comb begin
        acc_rdata = '0;
        if (acc_en && !acc_we && hit) begin
            acc_rdata[RCC_DATA_W-1:FLD_LSB] = st;
        end
    end

    rcc_decode #(
        .ADDR_W  (ADDR_W),
        .REG_OFF (REG_OFF)
    ) u_decode (
        .addr (acc_addr),
        .hit  (hit)
    );

    rcc_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_bits  (wr_bits),
        .load_por (load_por),
        .st       (st)
    );

    rcc_event_count #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .clr     (fire_por),
        .is_zero (cnt_zero)
    );

    rcc_req u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_por (fire_por),
        .fire_xir (fire_xir),
        .req      (rst_req),
        .cause    (rst_cause)
    );

    AST_RD_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rdata[FLD_LSB-1:0] == '0); // R1
    AST_POR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && cnt_zero) |=> (st == POR_VAL)); // R8
    AST_KEEP_ON_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !cnt_zero) |=> $stable(st)); // R8
    AST_REQ_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(wr_en && (wr_bits[IDX_SPOR] || wr_bits[IDX_SXIR]))); // R6
    AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (rst_cause == !$past(wr_bits[IDX_SPOR]))); // R7
    AST_NO_REQ_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !sysrst_n |=> !rst_req); // R11
endmodule

// File: tb/rst_cause_ctrl_tb.sv
// Bench: vector table walked by one loop, then directed reset and corner tests.
module rst_cause_ctrl_tb;
    localparam int ADDR_W = 16;

    typedef struct packed {
        logic [15:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp_rd;
        logic        exp_req;
        logic        exp_cause;
    } vec_t;

    localparam int NVEC = 10;
    // Starting state: 0x80000000. Each vector writes, then reads 0xF024.
    localparam vec_t VECS [NVEC] = '{
        '{16'hF024, 32'h0000_0000, 32'h8000_0000, 1'b0, 1'b0},  // R3 zero keeps
        '{16'hF024, 32'h07FF_FFFF, 32'h8000_0000, 1'b0, 1'b0},  // R5 low bits ignored
        '{16'hF020, 32'hFFFF_FFFF, 32'h8000_0000, 1'b0, 1'b0},  // R11 companion word
        '{16'h1024, 32'hF800_0000, 32'h8000_0000, 1'b0, 1'b0},  // R11 foreign address
        '{16'hF024, 32'h8000_0000, 32'h0000_0000, 1'b0, 1'b0},  // R3 W1C bit 31
        '{16'hF024, 32'h2000_0000, 32'h2000_0000, 1'b1, 1'b1},  // R7 soft XIR
        '{16'hF024, 32'h0000_0000, 32'h2000_0000, 1'b0, 1'b0},  // R4 zero keeps set
        '{16'hF024, 32'h1800_0000, 32'h2000_0000, 1'b0, 1'b0},  // R3 button bits no set
        '{16'hF024, 32'h6000_0000, 32'h6000_0000, 1'b1, 1'b0},  // R7 both -> cause 0
        '{16'hF024, 32'hF800_0000, 32'h6000_0000, 1'b1, 1'b0}   // R6 soft POR
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sysrst_n = 1'b0;
    logic              acc_en = 1'b0;
    logic              acc_we = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic [31:0]       acc_wdata = '0;
    logic [31:0]       acc_rdata;
    logic              rst_req;
    logic              rst_cause;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rst_cause_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sysrst_n  (sysrst_n),
        .acc_en    (acc_en),
        .acc_we    (acc_we),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .acc_rdata (acc_rdata),
        .rst_req   (rst_req),
        .rst_cause (rst_cause)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Write at a falling edge; returns at the next falling edge, when the
    // registered request for this write is visible.
    task automatic do_write(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0;
    endtask

    task automatic do_read(input logic [15:0] a, output logic [31:0] d);
        acc_en = 1'b1; acc_we = 1'b0; acc_addr = a;
        #1;
        d = acc_rdata;
        acc_en = 1'b0;
    endtask

    task automatic do_sysreset();
        @(negedge clk);
        sysrst_n = 1'b0;
        @(negedge clk);
        sysrst_n = 1'b1;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        // Power-up: clear, then one system reset event as rst_n releases.
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        sysrst_n = 1'b1;
        check("R2 rst_req idle", {31'd0, rst_req}, 32'd0);
        do_read(16'hF024, rd);
        check("R2 power-on word", rd, 32'h8000_0000);
        do_read(16'hF020, rd);
        check("R1 companion word", rd, 32'h0);
        do_read(16'hF028, rd);
        check("R1 next window", rd, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            do_write(VECS[i].addr, VECS[i].wdata);
            check("R6 R7 req", {31'd0, rst_req}, {31'd0, VECS[i].exp_req});
            if (VECS[i].exp_req) begin
                check("R7 cause", {31'd0, rst_cause}, {31'd0, VECS[i].exp_cause});
            end
            do_read(16'hF024, rd);
            check("R1 R3 R4 R5 read", rd, VECS[i].exp_rd);
        end

        // R6: pulse drops one cycle after the last requesting write.
        @(negedge clk);
        check("R6 pulse ends", {31'd0, rst_req}, 32'd0);

        // R9: the soft power-on zeroed the count; next event is a power-on.
        do_sysreset();
        do_read(16'hF024, rd);
        check("R9 power-on after soft request", rd, 32'h8000_0000);

        // R8: event with nonzero count leaves the word unchanged.
        do_write(16'hF024, 32'h2000_0000);
        check("R7 xir cause", {31'd0, rst_cause}, 32'd1);
        do_sysreset();
        do_read(16'hF024, rd);
        check("R8 word kept", rd, 32'hA000_0000);

        // R10: many events with no soft power-on never reload power-on.
        do_write(16'hF024, 32'h8000_0000);
        for (int k = 0; k < 40; k++) begin
            do_sysreset();
        end
        do_read(16'hF024, rd);
        check("R10 no false power-on", rd, 32'h2000_0000);

        // R11: write while sysrst_n is low is ignored and raises nothing.
        @(negedge clk);
        sysrst_n = 1'b0;
        acc_en = 1'b1; acc_we = 1'b1; acc_addr = 16'hF024; acc_wdata = 32'hF800_0000;
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0;
        check("R11 no req in reset", {31'd0, rst_req}, 32'd0);
        sysrst_n = 1'b1;
        @(negedge clk);
        check("R11 no req after", {31'd0, rst_req}, 32'd0);
        do_read(16'hF024, rd);
        check("R11 word unchanged", rd, 32'h2000_0000);

        // R2: a fresh power-up clear followed by an event gives the power-on word.
        @(negedge clk);
        rst_n = 1'b0; sysrst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        sysrst_n = 1'b1;
        do_read(16'hF024, rd);
        check("R2 repeat power-up", rd, 32'h8000_0000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule